// File: doc/BRIEF.md
# Four-Port Power Sequencing Arbiter

This block decides when each of four power-sourcing ports switches its output gate on or off. The aim is that no two ports change state on the same clock. A port asks to be powered by holding its request high. The arbiter starts one port at a time and keeps it in a startup phase for a fixed number of cycles. While a port is in startup, no other port may begin. A port is also started only while the fault timer reads zero and, when oscillator checking is enabled, while the oscillator is healthy.

Normal turn-offs are serialized as well. After a port switches off, no other port may switch off for a lockout window of 0.5 ms, which is derived from the clock-frequency parameter. Any emergency condition drops every gate at the next edge and ignores that window. The emergency conditions are the active-low hard reset, the chip-reset request, undervoltage on either supply, and over-temperature.

For each port the block also reports three things. Power-good is debounced on its rising edge only. Power-enable shows that the port has completed startup. Power-changed is a sticky flag that software clears by writing a one.

Top module: `pwr_seq_arb`

## Requirements
- R1: At most one port is in startup at any time. Startup lasts START_CYC clock edges from the gate turning on, and no other port's gate turns on during it.
- R2: No gate turns on while `flt_zero` is low.
- R3: While `osc_chk_en` and `osc_fail` are both high, no gate turns on.
- R4: When several ports qualify for the same kind of transition in one cycle, only the lowest-indexed port (bit 0 first) makes it.
- R5: A port whose gate is on is a turn-off candidate while its `pwr_off` bit is high or its `pwr_req` bit is low. A port with `pwr_off` high never turns on.
- R6: After a normal turn-off, no other normal turn-off happens for OFF_CYC = CLK_HZ/2000 clock edges.
- R7: While any emergency input is active (`hard_rst_n` low, or `chip_rst`, `uv_neg`, `uv_pos` or `over_temp` high), every gate is off after the next edge, regardless of the lockout. No gate turns on while the emergency lasts.
- R8: `pgood[i]` goes high once `pok[i]` has been sampled high with the gate on at PG_CYC consecutive edges. It drops in the same cycle that `pok[i]` or the gate goes low.
- R9: `pwr_en[i]` sets at the edge where the port's startup phase ends and clears at the edge where its gate turns off.
- R10: `pg_chg[i]` sets at every edge where `gate_en[i]` changes value. It stays set until a cycle with `pg_chg_clr[i]` high, and a new change in that same cycle wins over the clear.
- R11: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the logic |
| pwr_req | input | N | Per-port request to be powered |
| pwr_off | input | N | Per-port forced power-off command |
| pok | input | N | Per-port output voltage is near the negative rail |
| flt_zero | input | 1 | Fault timer is at zero |
| osc_chk_en | input | 1 | Enables the oscillator-health start condition |
| osc_fail | input | 1 | Oscillator reported faulty |
| hard_rst_n | input | 1 | Emergency: active-low hard shutdown |
| chip_rst | input | 1 | Emergency: chip reset request |
| uv_neg | input | 1 | Emergency: negative supply undervoltage |
| uv_pos | input | 1 | Emergency: positive supply undervoltage |
| over_temp | input | 1 | Emergency: thermal shutdown |
| pg_chg_clr | input | N | Write-one-to-clear strobe for `pg_chg` |
| gate_en | output | N | Per-port power gate enable |
| pgood | output | N | Per-port debounced power-good |
| pwr_en | output | N | Per-port powered-up status |
| pg_chg | output | N | Per-port sticky power-state-changed flag |

## Verification
The hardest case to reach from the ports has three parts at once. A normal turn-off is still inside its lockout window, a second port is queued to turn off, and a third port is mid-startup when an emergency arrives. Directed phases build this by releasing all requests together, so that the turn-offs queue up one after another, and then raising `over_temp` while a fresh startup is in progress. A long random phase then toggles requests, power-off bits, `pok`, the start conditions and short emergency bursts. Throughout, a behavioural model tracks every output on every clock.

// File: rtl/pwr_seq_arb.sv
module pwr_seq_arb #(
  parameter int N         = 4,
  parameter int CLK_HZ    = 200_000_000,
  parameter int START_CYC = 12_000_000,
  parameter int PG_CYC    = 2_000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pwr_req,
  input  logic [N-1:0] pwr_off,
  input  logic [N-1:0] pok,
  input  logic         flt_zero,
  input  logic         osc_chk_en,
  input  logic         osc_fail,
  input  logic         hard_rst_n,
  input  logic         chip_rst,
  input  logic         uv_neg,
  input  logic         uv_pos,
  input  logic         over_temp,
  input  logic [N-1:0] pg_chg_clr,
  output logic [N-1:0] gate_en,
  output logic [N-1:0] pgood,
  output logic [N-1:0] pwr_en,
  output logic [N-1:0] pg_chg
);
  localparam int OFF_CYC = CLK_HZ / 2000;
  localparam int LW = $clog2(OFF_CYC + 1);
  localparam int SW = $clog2(START_CYC + 1);
  localparam int PW = $clog2(PG_CYC + 1);

  logic [N-1:0]  gate_q, start_q, pen_q, chg_q;
  logic [SW-1:0] scnt;
  logic [LW-1:0] lock;

  wire emerg = !hard_rst_n || chip_rst || uv_neg || uv_pos || over_temp;

  wire [N-1:0] off_cand = gate_q & (pwr_off | ~pwr_req);
  wire [N-1:0] off_pick = off_cand & (~off_cand + 1'b1);
  wire         off_go   = !emerg && (lock == '0) && (|off_cand);
  wire [N-1:0] off_mask = emerg ? gate_q : (off_go ? off_pick : '0);

  wire [N-1:0] on_cand  = ~gate_q & pwr_req & ~pwr_off;
  wire         on_ok    = !emerg && (start_q == '0) && flt_zero && !(osc_chk_en && osc_fail);
  wire [N-1:0] on_mask  = on_ok ? (on_cand & (~on_cand + 1'b1)) : '0;

  wire         st_done  = (|start_q) && (scnt == '0);
  wire [N-1:0] gate_d   = (gate_q & ~off_mask) | on_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_q  <= '0;
      start_q <= '0;
      pen_q   <= '0;
      chg_q   <= '0;
      scnt    <= '0;
      lock    <= '0;
    end else begin
      gate_q  <= gate_d;
      start_q <= on_mask | (st_done ? '0 : (start_q & ~off_mask));
      pen_q   <= (pen_q | (st_done ? start_q : '0)) & ~off_mask;
      chg_q   <= (chg_q & ~pg_chg_clr) | (gate_q ^ gate_d);
      if (|on_mask)                     scnt <= SW'(START_CYC - 1);
      else if (|start_q && scnt != '0)  scnt <= scnt - 1'b1;
      if (off_go)                       lock <= LW'(OFF_CYC - 1);
      else if (lock != '0)              lock <= lock - 1'b1;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_pg
    logic [PW-1:0] pgc;
    logic          pg_r;
    always_ff @(posedge clk) begin
      if (!rst_n || !(gate_q[i] && pok[i])) begin
        pgc  <= '0;
        pg_r <= 1'b0;
      end else if (pgc == PW'(PG_CYC - 1)) begin
        pg_r <= 1'b1;
      end else begin
        pgc <= pgc + 1'b1;
      end
    end
    assign pgood[i] = pg_r & pok[i] & gate_q[i];
  end

  assign gate_en = gate_q;
  assign pwr_en  = pen_q;
  assign pg_chg  = chg_q;

  // R1
  one_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gate_en & ~$past(gate_en)));
  // R2 R3
  start_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(gate_en & ~$past(gate_en))) |-> $past(flt_zero && !(osc_chk_en && osc_fail)));
  // R7
  emerg_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!hard_rst_n || chip_rst || uv_neg || uv_pos || over_temp) |-> (gate_en == '0));
  // R6
  lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(~gate_en & $past(gate_en))) && !$past(emerg)) |-> ($past(lock) == '0));
  // R9
  pen_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwr_en & ~gate_en) == '0));
  // R10
  chg_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((gate_en ^ $past(gate_en)) & ~pg_chg) == '0));
endmodule

// File: tb/pwr_seq_arb_tb_top.sv
module pwr_seq_arb_tb_top;
  localparam int N = 4, CLK_HZ = 40_000, START_CYC = 6, PG_CYC = 4;
  localparam int OFF_CYC = CLK_HZ / 2000;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] pwr_req = 0, pwr_off = 0, pok = 0, pg_chg_clr = 0;
  logic flt_zero = 1, osc_chk_en = 0, osc_fail = 0;
  logic hard_rst_n = 1, chip_rst = 0, uv_neg = 0, uv_pos = 0, over_temp = 0;
  wire [N-1:0] gate_en, pgood, pwr_en, pg_chg;

  always #2.5 clk = ~clk;

  pwr_seq_arb #(.N(N), .CLK_HZ(CLK_HZ), .START_CYC(START_CYC), .PG_CYC(PG_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_req(pwr_req), .pwr_off(pwr_off), .pok(pok),
    .flt_zero(flt_zero), .osc_chk_en(osc_chk_en), .osc_fail(osc_fail),
    .hard_rst_n(hard_rst_n), .chip_rst(chip_rst), .uv_neg(uv_neg), .uv_pos(uv_pos),
    .over_temp(over_temp), .pg_chg_clr(pg_chg_clr),
    .gate_en(gate_en), .pgood(pgood), .pwr_en(pwr_en), .pg_chg(pg_chg));

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;
  int m_gate[N], m_st[N], m_pen[N], m_chg[N], m_pgc[N];
  int m_scnt = 0, m_lock = 0;

  // behavioural reference, updated at each edge from pre-edge inputs
  always @(posedge clk) begin
    int offm[N], onm[N], ng[N];
    bit emerg, anyst, stdone, offgo, onany, ok;
    cyc++;
    if (!rst_n) begin
      foreach (m_gate[i]) begin m_gate[i]=0; m_st[i]=0; m_pen[i]=0; m_chg[i]=0; m_pgc[i]=0; end
      m_scnt = 0; m_lock = 0;
    end else begin
      emerg = !hard_rst_n || chip_rst || uv_neg || uv_pos || over_temp;
      anyst = 0;
      foreach (m_st[i]) if (m_st[i] != 0) anyst = 1;
      stdone = anyst && m_scnt == 0;
      offgo = 0; onany = 0;
      foreach (offm[i]) begin offm[i] = 0; onm[i] = 0; end
      if (emerg) foreach (offm[i]) offm[i] = m_gate[i];
      else if (m_lock == 0)
        for (int i = 0; i < N; i++)
          if (!offgo && m_gate[i] != 0 && (pwr_off[i] || !pwr_req[i])) begin offm[i] = 1; offgo = 1; end
      ok = !emerg && !anyst && flt_zero && !(osc_chk_en && osc_fail);
      if (ok)
        for (int i = 0; i < N; i++)
          if (!onany && m_gate[i] == 0 && pwr_req[i] && !pwr_off[i]) begin onm[i] = 1; onany = 1; end
      for (int i = 0; i < N; i++) begin
        if (m_gate[i] != 0 && pok[i]) begin if (m_pgc[i] < PG_CYC) m_pgc[i]++; end
        else m_pgc[i] = 0;
        ng[i] = ((m_gate[i] != 0 && offm[i] == 0) || onm[i] != 0) ? 1 : 0;
        m_pen[i] = ((m_pen[i] != 0 || (stdone && m_st[i] != 0)) && offm[i] == 0) ? 1 : 0;
        m_chg[i] = ((m_chg[i] != 0 && !pg_chg_clr[i]) || ng[i] != m_gate[i]) ? 1 : 0;
      end
      for (int i = 0; i < N; i++)
        m_st[i] = onany ? onm[i] : (stdone ? 0 : ((m_st[i] != 0 && offm[i] == 0) ? 1 : 0));
      if (onany) m_scnt = START_CYC - 1;
      else if (anyst && m_scnt > 0) m_scnt--;
      if (offgo) m_lock = OFF_CYC - 1;
      else if (m_lock > 0) m_lock--;
      foreach (m_gate[i]) m_gate[i] = ng[i];
    end
  end

  task automatic chk(input logic [N-1:0] act, input logic [N-1:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%b expected=%b", req, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [N-1:0] eg, ep, ee, ec;
    if (rst_n && !done) begin
      for (int i = 0; i < N; i++) begin
        eg[i] = m_gate[i] != 0;
        ep[i] = (m_pgc[i] >= PG_CYC) && pok[i] && m_gate[i] != 0;
        ee[i] = m_pen[i] != 0;
        ec[i] = m_chg[i] != 0;
      end
      chk(gate_en, eg, "R1 R2 R3 R4 R5 R6 R7 gate_en");
      chk(pgood,   ep, "R8 pgood");
      chk(pwr_en,  ee, "R9 pwr_en");
      chk(pg_chg,  ec, "R10 pg_chg");
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    step(3);
    // R11: reset state
    chk(gate_en | pgood | pwr_en | pg_chg, '0, "R11 reset");
    rst_n = 1;
    // R2: fault timer not zero blocks starts
    flt_zero = 0; pwr_req = 4'hF; step(10);
    chk(gate_en, 4'h0, "R2 blocked by flt_zero");
    // R3: oscillator check
    flt_zero = 1; osc_chk_en = 1; osc_fail = 1; step(10);
    chk(gate_en, 4'h0, "R3 blocked by osc_fail");
    osc_fail = 0; step(2);
    // R4: lowest port first
    chk(gate_en, 4'h1, "R4 port0 first");
    step(START_CYC);
    chk(gate_en, 4'h3, "R1 R4 port1 after startup");
    step(3 * START_CYC); pok = 4'hF; step(PG_CYC + 2);
    chk(pgood, 4'hF, "R8 pgood after delay");
    pok[1] = 0; #0.5;
    chk(pgood, 4'hD, "R8 immediate drop");
    step(1); pok[1] = 1; step(2);
    // R5 + R6: release all, serialized off with lockout
    pwr_req = 4'h0; step(OFF_CYC * 4 + 10);
    chk(gate_en, 4'h0, "R6 all off after lockouts");
    pg_chg_clr = 4'hF; step(1); pg_chg_clr = 0; step(1);
    chk(pg_chg, 4'h0, "R10 cleared");
    // R5: pwr_off keeps a port dark
    pwr_off = 4'h4; pwr_req = 4'hF; step(5 * START_CYC);
    chk(gate_en, 4'hB, "R5 pwr_off port stays off");
    // R7: emergency mid-startup and during lockout
    pwr_off = 4'h0; step(2); pwr_req = 4'h7; step(1); over_temp = 1; step(1);
    chk(gate_en, 4'h0, "R7 emergency off");
    step(5); over_temp = 0; step(40);
    // random phase
    for (int k = 0; k < 3000; k++) begin
      for (int i = 0; i < N; i++) begin
        if ($urandom % 16 == 0) pwr_req[i] = ~pwr_req[i];
        if ($urandom % 40 == 0) pwr_off[i] = ~pwr_off[i];
        if ($urandom % 4 == 0)  pok[i] = ~pok[i];
      end
      pg_chg_clr = ($urandom % 8 == 0) ? N'($urandom) : '0;
      flt_zero = ($urandom % 10) != 0;
      osc_chk_en = ($urandom % 2) != 0;
      osc_fail = ($urandom % 10) == 0;
      hard_rst_n = ($urandom % 300) != 0;
      chip_rst = ($urandom % 300) == 0;
      uv_neg = ($urandom % 300) == 0;
      uv_pos = ($urandom % 300) == 0;
      over_temp = ($urandom % 300) == 0;
      step(1);
    end
    finish_run();
  end

  initial begin
    #(5 * 60000);
    bad++; total++;
    $display("FAIL watchdog expired at cycle %0d: actual=running expected=done", cyc);
    finish_run();
  end
endmodule